// File: doc/BRIEF.md
# Per-Queue Residence Time and Congestion Monitor

This block measures how long each frame stays inside a switch and keeps, for every egress queue, the evidence needed to tell timing spikes apart from congestion. When a frame is accepted into a queue, the ingress timestamp is stored in a small in-order tag FIFO that belongs to that queue. When the queue sends a frame, the oldest stored tag is removed. The residence time is then the egress timestamp minus that tag, taken modulo 2^TS_W, so the figure includes any time spent waiting in the queue or behind a gate or shaper.

For each queue the block keeps the smallest and the largest residence time, a saturating sample count, a peak-depth watermark, a saturating drop counter and a sticky tag-overflow flag. Peak-to-peak jitter is the maximum minus the minimum. A one-cycle clear strobe resets every statistic at the same moment, so any measurement window can be taken. A queue select input picks which queue drives the readout outputs. The timestamp tap point is a build-time parameter, and its value is presented on an output so that logs can record it.

Top module: `residence_mon`

## Requirements
- R1: On an egress event for queue q whose tag FIFO is not empty, the sample is egr_ts_i minus the oldest pending ingress timestamp of queue q, taken modulo 2^TS_W. Tags are paired first-in first-out. The new statistics appear on the readout from the first clock edge after the event.
- R2: Per queue, rd_min_o and rd_max_o hold the smallest and largest sample since reset or clear, and rd_jitter_o equals max minus min. When a queue has no samples, min reads all-ones, max reads 0 and jitter reads 0.
- R3: An ingress event to a queue that already holds TAG_DEPTH tags, with no pop in the same cycle, is discarded and sets that queue's bit in ovf_o. The bit stays set until clear. An egress event on an empty FIFO changes no statistic.
- R4: Each cycle, a queue's watermark takes the value of its depth input when that value is greater than the stored peak.
- R5: Each drop_i[q] high cycle adds one to the drop counter of queue q. The counter stops at all-ones.
- R6: Each paired sample adds one to the sample count of its queue. The count stops at all-ones.
- R7: One cycle of clear_i sets every queue to min all-ones, and max, watermark, drops, count and ovf to zero. Clear wins over any update in the same cycle. Tags already in the FIFOs are kept.
- R8: tap_mode_o always presents the configured tap-point mode (0 MAC, 1 PCS, 2 pre-queue, 3 post-queue).
- R9: Events addressed to one queue leave the statistics and flags of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ing_valid_i | input | 1 | Frame entered a queue this cycle |
| ing_queue_i | input | QW | Queue of the ingress frame |
| ing_ts_i | input | TS_W | Ingress tap timestamp |
| egr_valid_i | input | 1 | Frame left a queue this cycle |
| egr_queue_i | input | QW | Queue of the egress frame |
| egr_ts_i | input | TS_W | Egress tap timestamp |
| depth_i | input | NUM_Q*DEPTH_W | Current depth of every queue, queue q at bits [q*DEPTH_W +: DEPTH_W] |
| drop_i | input | NUM_Q | Per-queue drop strobes |
| clear_i | input | 1 | Clear all statistics |
| rd_queue_i | input | QW | Queue selected for readout |
| rd_min_o | output | TS_W | Minimum residence time |
| rd_max_o | output | TS_W | Maximum residence time |
| rd_jitter_o | output | TS_W | Max minus min |
| rd_wmark_o | output | DEPTH_W | Peak depth |
| rd_drops_o | output | CNT_W | Drop count |
| rd_count_o | output | CNT_W | Sample count |
| ovf_o | output | NUM_Q | Sticky tag-FIFO overflow flags |
| tap_mode_o | output | 2 | Configured tap-point mode |

## Verification
Some properties are checked by assertions on every cycle and for every queue. The minimum never exceeds the maximum once a sample exists. The watermark never falls below the previous cycle's depth. The drop counter and the sample count never decrease except on clear. Overflow flags stay set. A clear leaves every statistic at its reset value. Other behaviour can only be shown by the bench's scenarios. These are the actual residence values, including timestamp wraparound, and first-in first-out pairing of tags. They also cover the discarded ingress on overflow, egress on an empty FIFO being ignored, saturation at all-ones, clear winning over a same-cycle drop, and tags surviving a clear.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic [1:0] {
    TAP_MAC    = 2'd0,
    TAP_PCS    = 2'd1,
    TAP_PRE_Q  = 2'd2,
    TAP_POST_Q = 2'd3
  } tap_mode_e;
endpackage

// File: rtl/rtm_tag_fifo.sv
// In-order timestamp tag store; DEPTH must be a power of two >= 2.
module rtm_tag_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/rtm_q_stats.sv
module rtm_q_stats #(
  parameter int TS_W    = 16,
  parameter int DEPTH_W = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               smp_vld_i,
  input  logic [TS_W-1:0]    smp_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               drop_i,
  input  logic               ovf_evt_i,
  output logic [TS_W-1:0]    min_o,
  output logic [TS_W-1:0]    max_o,
  output logic [DEPTH_W-1:0] wm_o,
  output logic [CNT_W-1:0]   drops_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               ovf_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_o   <= '1;
      max_o   <= '0;
      wm_o    <= '0;
      drops_o <= '0;
      cnt_o   <= '0;
      ovf_o   <= 1'b0;
    end else if (clear_i) begin
      min_o   <= '1;
      max_o   <= '0;
      wm_o    <= '0;
      drops_o <= '0;
      cnt_o   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (smp_vld_i) begin
        if (smp_i < min_o) min_o <= smp_i;
        if (smp_i > max_o) max_o <= smp_i;
        if (cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
      end
      if (depth_i > wm_o) wm_o <= depth_i;
      if (drop_i && drops_o != CNT_SAT) drops_o <= drops_o + 1'b1;
      if (ovf_evt_i) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/residence_mon.sv
module residence_mon #(
  parameter int                 NUM_Q     = 4,
  parameter int                 TS_W      = 16,
  parameter int                 TAG_DEPTH = 4,
  parameter int                 DEPTH_W   = 8,
  parameter int                 CNT_W     = 4,
  parameter rtm_pkg::tap_mode_e TAP_MODE  = rtm_pkg::TAP_MAC,
  localparam int                QW        = $clog2(NUM_Q)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ing_valid_i,
  input  logic [QW-1:0]            ing_queue_i,
  input  logic [TS_W-1:0]          ing_ts_i,
  input  logic                     egr_valid_i,
  input  logic [QW-1:0]            egr_queue_i,
  input  logic [TS_W-1:0]          egr_ts_i,
  input  logic [NUM_Q*DEPTH_W-1:0] depth_i,
  input  logic [NUM_Q-1:0]         drop_i,
  input  logic                     clear_i,
  input  logic [QW-1:0]            rd_queue_i,
  output logic [TS_W-1:0]          rd_min_o,
  output logic [TS_W-1:0]          rd_max_o,
  output logic [TS_W-1:0]          rd_jitter_o,
  output logic [DEPTH_W-1:0]       rd_wmark_o,
  output logic [CNT_W-1:0]         rd_drops_o,
  output logic [CNT_W-1:0]         rd_count_o,
  output logic [NUM_Q-1:0]         ovf_o,
  output logic [1:0]               tap_mode_o
);
  logic [NUM_Q-1:0][TS_W-1:0]    min_a, max_a;
  logic [NUM_Q-1:0][DEPTH_W-1:0] wm_a;
  logic [NUM_Q-1:0][CNT_W-1:0]   drp_a, cnt_a;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic            ing_hit, egr_hit, empty, full, push, pop, ovf_evt;
    logic [TS_W-1:0] head, smp;

    assign ing_hit = ing_valid_i && (ing_queue_i == QW'(g));
    assign egr_hit = egr_valid_i && (egr_queue_i == QW'(g));
    assign pop     = egr_hit && !empty;
    // a same-cycle pop frees a slot for the push
    assign push    = ing_hit && (!full || pop);
    assign ovf_evt = ing_hit && full && !pop;
    assign smp     = egr_ts_i - head;

    rtm_tag_fifo #(.W(TS_W), .DEPTH(TAG_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push),
      .pop_i   (pop),
      .data_i  (ing_ts_i),
      .head_o  (head),
      .empty_o (empty),
      .full_o  (full)
    );

    rtm_q_stats #(.TS_W(TS_W), .DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_stats (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (clear_i),
      .smp_vld_i (pop),
      .smp_i     (smp),
      .depth_i   (depth_i[g*DEPTH_W +: DEPTH_W]),
      .drop_i    (drop_i[g]),
      .ovf_evt_i (ovf_evt),
      .min_o     (min_a[g]),
      .max_o     (max_a[g]),
      .wm_o      (wm_a[g]),
      .drops_o   (drp_a[g]),
      .cnt_o     (cnt_a[g]),
      .ovf_o     (ovf_o[g])
    );
  end

  always_comb begin
    rd_min_o    = min_a[rd_queue_i];
    rd_max_o    = max_a[rd_queue_i];
    rd_wmark_o  = wm_a[rd_queue_i];
    rd_drops_o  = drp_a[rd_queue_i];
    rd_count_o  = cnt_a[rd_queue_i];
    rd_jitter_o = (cnt_a[rd_queue_i] != '0) ? (max_a[rd_queue_i] - min_a[rd_queue_i]) : '0;
  end

  assign tap_mode_o = TAP_MODE;
endmodule

// File: rtl/rtm_checker.sv
module rtm_checker #(
  parameter int NUM_Q   = 4,
  parameter int TS_W    = 16,
  parameter int DEPTH_W = 8,
  parameter int CNT_W   = 4
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              clear_i,
  input logic [NUM_Q*DEPTH_W-1:0]          depth_i,
  input logic [NUM_Q-1:0][TS_W-1:0]        min_a,
  input logic [NUM_Q-1:0][TS_W-1:0]        max_a,
  input logic [NUM_Q-1:0][DEPTH_W-1:0]     wm_a,
  input logic [NUM_Q-1:0][CNT_W-1:0]       drp_a,
  input logic [NUM_Q-1:0][CNT_W-1:0]       cnt_a,
  input logic [NUM_Q-1:0]                  ovf_o
);
  for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
    a_r2_min_le_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_a[g] != '0) |-> (min_a[g] <= max_a[g]));
    a_r4_wm_covers_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i |=> (wm_a[g] >= $past(depth_i[g*DEPTH_W +: DEPTH_W]) && wm_a[g] >= $past(wm_a[g])));
    a_r5_drops_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i |=> (drp_a[g] >= $past(drp_a[g])));
    a_r6_count_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i |=> (cnt_a[g] >= $past(cnt_a[g])));
    a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[g] && !clear_i) |=> ovf_o[g]);
    a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (min_a[g] == '1 && max_a[g] == '0 && wm_a[g] == '0 &&
                   drp_a[g] == '0 && cnt_a[g] == '0 && !ovf_o[g]));
  end
endmodule

bind residence_mon rtm_checker #(
  .NUM_Q(NUM_Q), .TS_W(TS_W), .DEPTH_W(DEPTH_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear_i (clear_i),
  .depth_i (depth_i),
  .min_a   (min_a),
  .max_a   (max_a),
  .wm_a    (wm_a),
  .drp_a   (drp_a),
  .cnt_a   (cnt_a),
  .ovf_o   (ovf_o)
);

// File: tb/residence_mon_tb_top.sv
`timescale 1ns/1ps
module residence_mon_tb_top;
  localparam int NQ = 4, TW = 16, TD = 4, DW = 8, CW = 4, QW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ing_valid = 0, egr_valid = 0, clear = 0;
  logic [QW-1:0] ing_q = 0, egr_q = 0, rd_q = 0;
  logic [TW-1:0] ing_ts = 0, egr_ts = 0;
  logic [NQ*DW-1:0] depth = 0;
  logic [NQ-1:0] drop = 0;
  logic [TW-1:0] rd_min, rd_max, rd_jit;
  logic [DW-1:0] rd_wm;
  logic [CW-1:0] rd_drops, rd_cnt;
  logic [NQ-1:0] ovf;
  logic [1:0] tap;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  residence_mon #(.NUM_Q(NQ), .TS_W(TW), .TAG_DEPTH(TD), .DEPTH_W(DW), .CNT_W(CW),
                  .TAP_MODE(rtm_pkg::TAP_PRE_Q)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ing_valid_i(ing_valid), .ing_queue_i(ing_q), .ing_ts_i(ing_ts),
    .egr_valid_i(egr_valid), .egr_queue_i(egr_q), .egr_ts_i(egr_ts),
    .depth_i(depth), .drop_i(drop), .clear_i(clear), .rd_queue_i(rd_q),
    .rd_min_o(rd_min), .rd_max_o(rd_max), .rd_jitter_o(rd_jit),
    .rd_wmark_o(rd_wm), .rd_drops_o(rd_drops), .rd_count_o(rd_cnt),
    .ovf_o(ovf), .tap_mode_o(tap)
  );

  typedef struct packed {
    logic [1:0]  q;
    logic [15:0] tin;
    logic [15:0] tout;
    logic [15:0] emin;
    logic [15:0] emax;
    logic [3:0]  ecnt;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 16'd100,   16'd130,   16'd30,    16'd30,    4'd1},
    '{2'd0, 16'd200,   16'd250,   16'd30,    16'd50,    4'd2},
    '{2'd1, 16'd65530, 16'd10,    16'd16,    16'd16,    4'd1},
    '{2'd0, 16'd300,   16'd310,   16'd10,    16'd50,    4'd3},
    '{2'd1, 16'd1000,  16'd1100,  16'd16,    16'd100,   4'd2},
    '{2'd2, 16'd0,     16'd0,     16'd0,     16'd0,     4'd1},
    '{2'd3, 16'd5,     16'd65535, 16'd65530, 16'd65530, 4'd1},
    '{2'd2, 16'd40,    16'd47,    16'd0,     16'd7,     4'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ingress(input logic [QW-1:0] q, input logic [TW-1:0] ts);
    @(negedge clk); ing_valid = 1; ing_q = q; ing_ts = ts;
    @(negedge clk); ing_valid = 0;
  endtask

  task automatic egress(input logic [QW-1:0] q, input logic [TW-1:0] ts);
    @(negedge clk); egr_valid = 1; egr_q = q; egr_ts = ts;
    @(negedge clk); egr_valid = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  task automatic sel(input logic [QW-1:0] q);
    rd_q = q; #1;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R8: reset state
    for (int q = 0; q < NQ; q++) begin
      sel(q[QW-1:0]);
      chk("R2 reset min", rd_min, 16'hFFFF);
      chk("R2 reset max", rd_max, 0);
      chk("R2 reset jitter", rd_jit, 0);
      chk("R7 reset wmark", rd_wm, 0);
      chk("R7 reset drops", rd_drops, 0);
      chk("R7 reset count", rd_cnt, 0);
    end
    chk("R3 reset ovf", ovf, 0);
    chk("R8 tap mode", tap, 2);

    // R1 R2 R9: vector table
    for (int i = 0; i < 8; i++) begin
      ingress(VEC[i].q, VEC[i].tin);
      egress(VEC[i].q, VEC[i].tout);
      sel(VEC[i].q);
      chk("R1 vec min", rd_min, VEC[i].emin);
      chk("R1 vec max", rd_max, VEC[i].emax);
      chk("R2 vec jitter", rd_jit, VEC[i].emax - VEC[i].emin);
      chk("R6 vec count", rd_cnt, VEC[i].ecnt);
    end

    // R1: in-order pairing of back-to-back tags
    pulse_clear();
    ingress(1, 10); ingress(1, 20); ingress(1, 30);
    egress(1, 40); egress(1, 60); egress(1, 100);
    sel(1);
    chk("R1 fifo min", rd_min, 30);
    chk("R1 fifo max", rd_max, 70);
    chk("R2 fifo jitter", rd_jit, 40);
    chk("R6 fifo count", rd_cnt, 3);

    // R3: egress on empty FIFO ignored
    egress(1, 500);
    sel(1);
    chk("R3 empty egress count", rd_cnt, 3);
    chk("R3 empty egress max", rd_max, 70);

    // R3 R9: overflow discards fifth tag
    pulse_clear();
    for (int i = 1; i <= 5; i++) ingress(2, i[TW-1:0]);
    chk("R3 ovf flag", ovf, 4'b0100);
    for (int i = 0; i < 5; i++) egress(2, 100);
    sel(2);
    chk("R3 ovf min", rd_min, 96);
    chk("R3 ovf max", rd_max, 99);
    chk("R3 ovf count", rd_cnt, 4);
    chk("R3 ovf sticky", ovf, 4'b0100);
    sel(1);
    chk("R9 other queue count", rd_cnt, 0);

    // R4: watermark peak
    pulse_clear();
    @(negedge clk); depth[3*DW +: DW] = 5;
    @(negedge clk); depth[3*DW +: DW] = 12;
    @(negedge clk); depth[3*DW +: DW] = 7;
    @(negedge clk); depth[3*DW +: DW] = 0;
    @(negedge clk);
    sel(3);
    chk("R4 wmark peak", rd_wm, 12);
    sel(0);
    chk("R9 wmark other", rd_wm, 0);

    // R5: drop counter saturation
    @(negedge clk); drop = 4'b0001;
    repeat (20) @(negedge clk);
    drop = 0;
    sel(0);
    chk("R5 drops saturate", rd_drops, 15);
    sel(1);
    chk("R9 drops other", rd_drops, 0);

    // R6: sample count saturation
    for (int i = 0; i < 20; i++) begin
      ingress(3, 0);
      egress(3, 3);
    end
    sel(3);
    chk("R6 count saturate", rd_cnt, 15);
    chk("R6 min after sat", rd_min, 3);

    // R7: clear wins over same-cycle drop, tags survive clear
    ingress(0, 1000);
    @(negedge clk); clear = 1; drop = 4'b0010;
    @(negedge clk); clear = 0; drop = 0;
    sel(1);
    chk("R7 clear beats drop", rd_drops, 0);
    sel(3);
    chk("R7 clear count", rd_cnt, 0);
    chk("R7 clear min", rd_min, 16'hFFFF);
    chk("R7 clear ovf", ovf, 0);
    egress(0, 1010);
    sel(0);
    chk("R7 tag kept max", rd_max, 10);
    chk("R7 tag kept count", rd_cnt, 1);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule